// File: doc/BRIEF.md
# Eight-Phase Delayed Output Launcher

This block sends one data word out on eight separate output copies. Each copy is launched at a different eighth of the slow data period, so that a board can wire all eight toward an external receiver whose input timing is unknown and keep the copy that works. At the default rates the slow period is 80 ns, the fast clock is 50 MHz (20 ns), and the eight launch points are 10 ns apart.

The block runs from a fast clock at four times the slow rate and uses both of its edges. A staging register captures the incoming word once per slow period. Two four-bit one-hot rings, one stepping on rising edges and one on falling edges, give eight phase enables. Each enable gates the clock-enable input of one output flop. Every flop runs on the free-running fast clock, and no clock is derived or gated. Output flops for even phases use the rising edge and those for odd phases use the falling edge, so neighbouring phases sit half a fast cycle apart.

Top module: `octa_phase_launcher`

## Requirements
- R1: While `rst` is high, all eight output words and the staging register clear to zero, and both rings return to the state with only bit 0 set.
- R2: Number the fast-clock edges after reset release from 0, starting with the first rising edge. Phase k (k = 0..7) is enabled on every edge e with e mod 8 = k. An output word changes only on an edge where its own phase is enabled.
- R3: Outputs with an even index update on rising edges and those with an odd index update on falling edges. Output k is enabled by bit k/2 of the rising ring when k is even, and by bit k/2 of the falling ring when k is odd.
- R4: The staging register loads `word_in` only when `word_stb` is high at a rising edge on which phase 0 is enabled.
- R5: A high `word_stb` at any other rising edge has no effect on the staging register or on any output.
- R6: On its enabled edge, output k takes the value the staging register held just before that edge. A word staged on a phase-0 edge appears on outputs 1 to 7 during the same slow period, and on output 0 at the next phase-0 edge.
- R7: Each output word is written at most once in any four consecutive fast cycles, and it holds its value between those writes.
- R8: Each ring always holds exactly one set bit. At every falling edge, the falling ring equals the rising ring rotated back by one position.
- R9: `DATA_W` sets the word width, with a default of 8. The outputs form a packed array of eight words, and word k is `launch_q[k]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock at four times the slow data rate; both edges are used |
| rst | input | 1 | Synchronous active-high reset |
| word_in | input | DATA_W | Data word from the slow domain |
| word_stb | input | 1 | Strobe asking for `word_in` to be staged |
| launch_q | output | 8 x DATA_W | Eight registered copies of the staged word, one per launch phase |

## Verification
The assertions assume that `rst` is released while the clock is low, so that the first edge after release is a rising one. If it is released while the clock is high, the falling ring steps half a cycle ahead, and the alignment and ordering checks no longer describe the intended phase sequence. The stimulus changes `rst`, `word_in` and `word_stb` only a quarter-cycle after a falling edge, which meets that assumption. It also keeps every input stable across both edges of a fast cycle. Strobes are placed both on phase-0 cycles and on the other three cycles, and the data values change every cycle, so that ignored strobes would show up in the outputs.

// File: rtl/launch_pkg.sv
package launch_pkg;
  localparam int NUM_PHASES = 8;
  localparam int RING_LEN   = NUM_PHASES / 2;
  localparam logic [RING_LEN-1:0] RING_INIT = RING_LEN'(1);
endpackage

// File: rtl/phase_ring.sv
module phase_ring
  import launch_pkg::*;
#(
  parameter bit FALL_EDGE = 1'b0
) (
  input  logic                clk,
  input  logic                rst,
  output logic [RING_LEN-1:0] ring
);

  logic [RING_LEN-1:0] ring_next;

  always_comb begin
    ring_next = {ring[RING_LEN-2:0], ring[RING_LEN-1]};
  end

  generate
    if (FALL_EDGE) begin : g_fall
      always_ff @(negedge clk) begin
        if (rst) ring <= RING_INIT;
        else     ring <= ring_next;
      end

      // R8
      ring_onehot_fall_chk: assert property (@(negedge clk) disable iff (rst)
        $countones(ring) == 1);
    end else begin : g_rise
      always_ff @(posedge clk) begin
        if (rst) ring <= RING_INIT;
        else     ring <= ring_next;
      end

      // R8
      ring_onehot_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(ring) == 1);
    end
  endgenerate

endmodule

// File: rtl/launch_slot.sv
module launch_slot #(
  parameter int DATA_W    = 8,
  parameter bit FALL_EDGE = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [DATA_W-1:0] d,
  output logic [DATA_W-1:0] q
);

  generate
    if (FALL_EDGE) begin : g_fall
      always_ff @(negedge clk) begin
        if (rst)     q <= '0;
        else if (en) q <= d;
      end

      // R2
      slot_enable_fall_chk: assert property (@(negedge clk) disable iff (rst)
        !$stable(q) |-> $past(en));
    end else begin : g_rise
      always_ff @(posedge clk) begin
        if (rst)     q <= '0;
        else if (en) q <= d;
      end

      // R2
      slot_enable_rise_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(q) |-> $past(en));
    end
  endgenerate

endmodule

// File: rtl/octa_phase_launcher.sv
module octa_phase_launcher
  import launch_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic [DATA_W-1:0]                  word_in,
  input  logic                               word_stb,
  output logic [NUM_PHASES-1:0][DATA_W-1:0]  launch_q
);

  logic [RING_LEN-1:0] rise_ring;
  logic [RING_LEN-1:0] fall_ring;
  logic [DATA_W-1:0]   stage_q;

  phase_ring #(.FALL_EDGE(1'b0)) u_rise_ring (
    .clk  (clk),
    .rst  (rst),
    .ring (rise_ring)
  );

  phase_ring #(.FALL_EDGE(1'b1)) u_fall_ring (
    .clk  (clk),
    .rst  (rst),
    .ring (fall_ring)
  );

  always_ff @(posedge clk) begin
    if (rst)                          stage_q <= '0;
    else if (word_stb && rise_ring[0]) stage_q <= word_in;
  end

  generate
    for (genvar k = 0; k < NUM_PHASES; k++) begin : g_slot
      localparam bit ODD = (k % 2) == 1;
      logic slot_en;
      if (ODD) begin : g_odd
        assign slot_en = fall_ring[k/2];
      end else begin : g_even
        assign slot_en = rise_ring[k/2];
      end

      launch_slot #(.DATA_W(DATA_W), .FALL_EDGE(ODD)) u_slot (
        .clk (clk),
        .rst (rst),
        .en  (slot_en),
        .d   (stage_q),
        .q   (launch_q[k])
      );
    end
  endgenerate

  // R4
  stage_load_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(stage_q) |-> $past(word_stb && rise_ring[0]));

  // R8
  ring_align_chk: assert property (@(negedge clk) disable iff (rst)
    fall_ring == {rise_ring[0], rise_ring[RING_LEN-1:1]});

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (stage_q == '0 && rise_ring == RING_INIT));

endmodule

// File: tb/octa_phase_launcher_tb.sv
module octa_phase_launcher_tb;
  localparam int PERIOD = 20;
  localparam int W      = 8;
  localparam int NP     = 8;

  logic                 clk = 1'b0;
  logic                 rst;
  logic [W-1:0]         word_in;
  logic                 word_stb;
  logic [NP-1:0][W-1:0] launch_q;

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  logic [W-1:0] exp_stage;
  logic [W-1:0] exp_q [NP];
  int           edge_no;
  bit           last_p0_stb;

  // R9: default width, eight words
  octa_phase_launcher #(.DATA_W(W)) u_dut (
    .clk      (clk),
    .rst      (rst),
    .word_in  (word_in),
    .word_stb (word_stb),
    .launch_q (launch_q)
  );

  always #(PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int idx,
                     input logic [W-1:0] got, input logic [W-1:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s edge %0d out%0d got %h exp %h", tag, edge_no, idx, got, exp);
    end
  endtask

  task automatic model_reset();
    exp_stage   = '0;
    last_p0_stb = 0;
    edge_no     = 0;
    for (int k = 0; k < NP; k++) exp_q[k] = '0;
  endtask

  task automatic model_edge(input bit stb, input logic [W-1:0] d);
    int ph;
    logic [W-1:0] old;
    ph  = edge_no % NP;
    old = exp_stage;
    if (ph == 0) begin
      last_p0_stb = stb;
      if (stb) exp_stage = d;
    end
    exp_q[ph] = old;
    for (int k = 0; k < NP; k++) begin
      string tag;
      if (k == ph) begin
        if (k == 1) tag = last_p0_stb ? "R4 R6" : "R5 R6";
        else        tag = (k % 2) ? "R2 R3 R8 odd" : "R2 R3 R8 even";
      end else begin
        tag = "R7";
      end
      chk(launch_q[k] === exp_q[k], tag, k, launch_q[k], exp_q[k]);
    end
    edge_no++;
  endtask

  task automatic run(input int cycles, input int pat);
    for (int n = 0; n < cycles; n++) begin
      bit stb;
      logic [W-1:0] d;
      case (pat)
        0:       stb = 1'b1;
        1:       stb = ((n * 5 + 1) % 3) == 0;
        default: stb = ((n % 4) != 0);
      endcase
      d        = W'(n * 53 + pat * 17 + 9);
      word_stb = stb;
      word_in  = d;
      @(posedge clk); #2;
      model_edge(stb, d);
      @(negedge clk); #2;
      model_edge(stb, d);
      #3;
    end
  endtask

  task automatic check_zero(input string tag);
    for (int k = 0; k < NP; k++)
      chk(launch_q[k] === '0, tag, k, launch_q[k], '0);
  endtask

  initial begin
    rst = 1'b1; word_stb = 1'b0; word_in = '0;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); #5;
    check_zero("R1");
    tests++;
    if ($bits(launch_q) != NP * W) begin
      fails++;
      $display("FAIL R9 width got %0d exp %0d", $bits(launch_q), NP * W);
    end
    rst = 1'b0;
    run(400, 0);
    run(400, 1);
    // mid-run reset with nonzero outputs, released in the low phase
    word_stb = 1'b1; word_in = 8'hA5;
    rst = 1'b1;
    @(posedge clk); @(negedge clk); @(posedge clk); @(negedge clk); #5;
    check_zero("R1");
    model_reset();
    rst = 1'b0;
    run(400, 2);
    run(200, 1);
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      done = 1;
      tests++;
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule